// File: doc/BRIEF.md
# Pad Interrupt Multiplexer with Trigger Conditioning

This block watches a wide bank of asynchronous input pads and steers any one of them onto each of eight interrupt request lines for a downstream interrupt controller. Every pad first passes through a two-stage synchroniser. Each output channel then picks one synchronised pad with its own selector. It cleans the selected signal with an optional glitch filter and turns it into a request. In level mode the request follows the pad, with either polarity. In edge mode the request is a single-clock pulse on a rising or falling transition.

Software sets the channels through four 32-bit word registers on a simple synchronous register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads return data one clock after `bus_rd`. When a channel's pad selector or trigger settings are rewritten, the channel restarts its filter and edge history from the newly selected pad. Reconfiguring therefore never produces a phantom edge.

Top module: `pad_irq_mux`

## Requirements
- R1: After reset every configuration word reads as zero and `irq_out` is all zero.
- R2: The four registers sit at byte offsets 0x0, 0x4, 0x8 and 0xC. Offset 0x0 holds the trigger word: bit c = 1 puts channel c in edge mode, and bit 16+c = 1 selects active-low/falling sense. Offsets 0x4 and 0x8 hold the 8-bit pad selectors of channels 0-3 and 4-7 at bit (c mod 4)*8. Offset 0xC holds a 4-bit filter length for channel c at bit 4*c. Each register reads back what was written, with bits 8-15 and 24-31 of the trigger word reading zero. Read data appears one clock after the read strobe. An offset that is not a multiple of 4 is ignored on write and reads as zero.
- R3: Any channel may select any pad, and several channels may select the same pad. A selector value at or above the pad count yields a constant low input.
- R4: In level mode with the polarity bit clear, the request is high while the selected pad is high. With the filter at 0 or 1, it reaches `irq_out` 4 clocks after the pad changes.
- R5: In level mode with the polarity bit set, the request is high while the selected pad is low.
- R6: In edge mode with the polarity bit clear, each rising pad transition gives exactly one clock of request, 4 clocks after the change, and a falling transition gives none.
- R7: In edge mode with the polarity bit set, each falling pad transition gives one clock of request, and a rising transition gives none.
- R8: With a filter length N of 2 or more, the selected pad must hold a new value for N consecutive clocks before it is accepted. A shorter pulse is discarded, and an accepted change reaches `irq_out` 3+N clocks after the pad changes.
- R9: A write to the trigger word, or to a selector word, reloads every affected channel from its current pad one clock after the write. A level channel shows the new pad state at that point, and an edge channel produces no pulse because of the reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_rd` |
| irq_out | output | NUM_CH | Interrupt requests, one per channel |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- An edge-mode channel never holds its request for two clocks.
- A reload leaves an edge channel quiet.
- The filtered value stays put while the input agrees with it.
- A level channel's request equals the previously accepted value corrected for polarity.
- The trigger word's reserved bits read as zero.

Other behaviour can only be shown by the bench's scenarios, which check outputs at exact cycles:
- The end-to-end latencies and the rejection of short glitches.
- Selectors shared between channels and selectors out of range.
- The absence of a phantom pulse after a channel is steered to a pad that is already high.

// File: rtl/pim_pkg.sv
package pim_pkg;
  parameter int SEL_W  = 8;   // pad selector width
  parameter int FLT_W  = 4;   // filter length width
  parameter int NUM_CH = 8;   // output channels
  parameter int REG_W  = 32;  // register word width

  typedef struct packed {
    logic             edge_md;  // 1 = edge sensing
    logic             act_low;  // 1 = low level / falling edge
    logic [SEL_W-1:0] sel;      // pad index
    logic [FLT_W-1:0] flt;      // filter length, 0 = bypass
  } ch_cfg_t;
endpackage

// File: rtl/pim_sync.sv
module pim_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/pim_regs.sv
module pim_regs
  import pim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output ch_cfg_t [NUM_CH-1:0]      cfg_o,
  output logic [NUM_CH-1:0]         reload_o
);
  localparam int CPW       = REG_W / SEL_W;             // selectors per word
  localparam int SEL_WORDS = (NUM_CH + CPW - 1) / CPW;
  localparam int TRIG_IDX  = 0;
  localparam int SEL_BASE  = 1;
  localparam int FLT_IDX   = SEL_BASE + SEL_WORDS;
  localparam int NUM_WORDS = FLT_IDX + 1;
  localparam int LOW_BASE  = REG_W / 2;
  localparam int WORD_W    = ADDR_W - 2;

  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] low_q;
  logic [SEL_W-1:0]  sel_q [NUM_CH];
  logic [FLT_W-1:0]  flt_q [NUM_CH];
  logic [NUM_CH-1:0] reload_q;
  logic [REG_W-1:0]  rdata_q;
  logic [REG_W-1:0]  img [NUM_WORDS];

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];

  // register writes and per-channel reload strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      low_q    <= '0;
      reload_q <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        sel_q[c] <= '0;
        flt_q[c] <= '0;
      end
    end else begin
      reload_q <= '0;
      if (wr_i && aligned) begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (int'(word) == TRIG_IDX) begin
            mode_q[c]   <= wdata_i[c];
            low_q[c]    <= wdata_i[LOW_BASE + c];
            reload_q[c] <= 1'b1;
          end
          if (int'(word) == SEL_BASE + c / CPW) begin
            sel_q[c]    <= wdata_i[(c % CPW) * SEL_W +: SEL_W];
            reload_q[c] <= 1'b1;
          end
          if (int'(word) == FLT_IDX) begin
            flt_q[c] <= wdata_i[c * FLT_W +: FLT_W];
          end
        end
      end
    end
  end

  // read image of all words
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) img[w] = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      img[TRIG_IDX][c]                                = mode_q[c];
      img[TRIG_IDX][LOW_BASE + c]                     = low_q[c];
      img[SEL_BASE + c / CPW][(c % CPW) * SEL_W +: SEL_W] = sel_q[c];
      img[FLT_IDX][c * FLT_W +: FLT_W]                = flt_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= (aligned && int'(word) < NUM_WORDS) ? img[word] : '0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
      assign cfg_o[g].edge_md = mode_q[g];
      assign cfg_o[g].act_low = low_q[g];
      assign cfg_o[g].sel     = sel_q[g];
      assign cfg_o[g].flt     = flt_q[g];
    end
  endgenerate

  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;

  AST_TRIG_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == '0) |=> (rdata_o[LOW_BASE-1:NUM_CH] == '0 && rdata_o[REG_W-1:LOW_BASE+NUM_CH] == '0)); // R2
endmodule

// File: rtl/pim_chan.sv
module pim_chan
  import pim_pkg::*;
#(
  parameter int PAD_SPAN = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PAD_SPAN-1:0] pads_i,
  input  ch_cfg_t             cfg_i,
  input  logic                reload_i,
  output logic                irq_o
);
  logic             raw;
  logic             filt_q, filt_d;
  logic             prev_q;
  logic             irq_q;
  logic [FLT_W-1:0] cnt_q, cnt_d;
  logic [FLT_W:0]   cnt_inc;

  assign raw     = pads_i[cfg_i.sel];
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // glitch filter: accept a new value after flt consecutive samples
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (cfg_i.flt == '0) begin
      filt_d = raw;
    end else if (raw != filt_q) begin
      if (cnt_inc >= {1'b0, cfg_i.flt}) begin
        filt_d = raw;
      end else begin
        cnt_d = cnt_inc[FLT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else if (reload_i) begin
      filt_q <= raw;
      prev_q <= raw;
      cnt_q  <= '0;
      irq_q  <= cfg_i.edge_md ? 1'b0 : (raw ^ cfg_i.act_low);
    end else begin
      filt_q <= filt_d;
      prev_q <= filt_q;
      cnt_q  <= cnt_d;
      if (cfg_i.edge_md) begin
        irq_q <= cfg_i.act_low ? (prev_q & ~filt_q) : (~prev_q & filt_q);
      end else begin
        irq_q <= filt_q ^ cfg_i.act_low;
      end
    end
  end

  assign irq_o = irq_q;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.edge_md && irq_q && !reload_i) |=> !irq_q); // R6
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (reload_i && cfg_i.edge_md) |=> !irq_q); // R9
  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.flt != '0 && raw == filt_q && !reload_i) |=> $stable(filt_q)); // R8
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.edge_md && !reload_i) |=> (irq_q == (prev_q ^ $past(cfg_i.act_low)))); // R4
endmodule

// File: rtl/pad_irq_mux.sv
module pad_irq_mux
  import pim_pkg::*;
#(
  parameter int NUM_PADS = 134,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic [NUM_CH-1:0]   irq_out
);
  localparam int PAD_SPAN = 1 << SEL_W;

  logic [NUM_PADS-1:0]  pad_s;
  logic [PAD_SPAN-1:0]  pad_ext;
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]    reload;

  pim_sync #(.W(NUM_PADS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_in),
    .q_o (pad_s)
  );

  // selectors beyond the pad count land on zero-filled positions
  assign pad_ext = PAD_SPAN'(pad_s);

  pim_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .rdata_o  (bus_rdata),
    .cfg_o    (cfg),
    .reload_o (reload)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      pim_chan #(.PAD_SPAN(PAD_SPAN)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .pads_i   (pad_ext),
        .cfg_i    (cfg[g]),
        .reload_i (reload[g]),
        .irq_o    (irq_out[g])
      );
    end
  endgenerate
endmodule

// File: tb/pad_irq_mux_tb.sv
module pad_irq_mux_tb;
  localparam int NP = 134;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] pad_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  typedef struct {
    int    at;
    int    ch;
    bit    val;
    string req;
  } exp_t;
  exp_t sb[$];

  pad_irq_mux #(.NUM_PADS(NP)) u_dut (
    .clk(clk), .rst(rst), .pad_in(pad_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver side: queue an expected output value for a given cycle
  task automatic expect_at(input int at, input int ch, input bit val, input string req);
    exp_t e;
    int i;
    e.at = at; e.ch = ch; e.val = val; e.req = req;
    i = 0;
    while (i < sb.size() && sb[i].at <= at) i++;
    sb.insert(i, e);
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      total++;
      if (sb[0].at < cyc || irq_out[sb[0].ch] !== sb[0].val) begin
        bad++;
        $display("FAIL %s ch%0d cyc=%0d got=%0b exp=%0b", sb[0].req, sb[0].ch, cyc,
                 irq_out[sb[0].ch], sb[0].val);
      end
      void'(sb.pop_front());
    end
  end

  task automatic direct_check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    w = cyc;
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    direct_check(req, bus_rdata, exp);
  endtask

  task automatic set_pad(input int idx, input bit v, output int k);
    @(negedge clk);
    pad_in[idx] = v;
    k = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int w, k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    direct_check("R1 irq", {24'd0, irq_out}, 32'd0);
    reg_rd(4'h0, 32'd0, "R1 trig");
    reg_rd(4'h4, 32'd0, "R1 sel_lo");
    reg_rd(4'h8, 32'd0, "R1 sel_hi");
    reg_rd(4'hC, 32'd0, "R1 flt");

    // R2: readback and reserved bits
    reg_wr(4'h0, 32'hFFFF_FFFF, w);
    reg_rd(4'h0, 32'h00FF_00FF, "R2 trig rsvd");
    reg_wr(4'h4, 32'h1234_5678, w);
    reg_rd(4'h4, 32'h1234_5678, "R2 sel_lo");
    reg_wr(4'h8, 32'h9ABC_DEF0, w);
    reg_rd(4'h8, 32'h9ABC_DEF0, "R2 sel_hi");
    reg_wr(4'hC, 32'hFEDC_BA98, w);
    reg_rd(4'hC, 32'hFEDC_BA98, "R2 flt");
    reg_wr(4'h5, 32'h0, w);
    reg_rd(4'h4, 32'h1234_5678, "R2 unaligned write ignored");
    reg_rd(4'h6, 32'h0, "R2 unaligned read");

    // working configuration
    reg_wr(4'h0, 32'h0, w);
    reg_wr(4'hC, 32'h0003_0000, w);          // ch4 filter 3
    reg_wr(4'h4, 32'h4746_8505, w);          // ch0=5 ch1=133 ch2=70 ch3=71
    reg_wr(4'h8, 32'hC814_140A, w);          // ch4=10 ch5=20 ch6=20 ch7=200
    reg_wr(4'h0, 32'h000A_000C, w);          // ch2,3 edge; ch1,3 low
    expect_at(w + 1, 1, 1'b1, "R5 idle low-level");
    expect_at(w + 1, 7, 1'b0, "R3 out-of-range sel");
    expect_at(w + 1, 0, 1'b0, "R4 idle");
    idle(4);

    // R4 level high
    set_pad(5, 1'b1, k);
    expect_at(k + 3, 0, 1'b0, "R4 before latency");
    expect_at(k + 4, 0, 1'b1, "R4 rise");
    idle(6);
    set_pad(5, 1'b0, k);
    expect_at(k + 3, 0, 1'b1, "R4 before latency");
    expect_at(k + 4, 0, 1'b0, "R4 fall");
    idle(6);

    // R5 level low
    set_pad(133, 1'b1, k);
    expect_at(k + 3, 1, 1'b1, "R5 before latency");
    expect_at(k + 4, 1, 1'b0, "R5 pad high");
    idle(6);
    set_pad(133, 1'b0, k);
    expect_at(k + 4, 1, 1'b1, "R5 pad low");
    idle(6);

    // R6 rising edge
    set_pad(70, 1'b1, k);
    expect_at(k + 3, 2, 1'b0, "R6 before");
    expect_at(k + 4, 2, 1'b1, "R6 pulse");
    expect_at(k + 5, 2, 1'b0, "R6 one clock");
    idle(6);
    set_pad(70, 1'b0, k);
    expect_at(k + 4, 2, 1'b0, "R6 no pulse on fall");
    expect_at(k + 5, 2, 1'b0, "R6 no pulse on fall");
    idle(6);

    // R7 falling edge
    set_pad(71, 1'b1, k);
    expect_at(k + 4, 3, 1'b0, "R7 no pulse on rise");
    expect_at(k + 5, 3, 1'b0, "R7 no pulse on rise");
    idle(6);
    set_pad(71, 1'b0, k);
    expect_at(k + 3, 3, 1'b0, "R7 before");
    expect_at(k + 4, 3, 1'b1, "R7 pulse");
    expect_at(k + 5, 3, 1'b0, "R7 one clock");
    idle(6);

    // R8 filter of 3: two-clock glitch rejected
    set_pad(10, 1'b1, k);
    idle(2);
    pad_in[10] = 1'b0;
    for (int d = 3; d <= 8; d++) expect_at(k + d, 4, 1'b0, "R8 glitch rejected");
    idle(8);
    set_pad(10, 1'b1, k);
    expect_at(k + 5, 4, 1'b0, "R8 still filtering");
    expect_at(k + 6, 4, 1'b1, "R8 accepted after 3");
    idle(8);

    // R3 shared pad
    set_pad(20, 1'b1, k);
    expect_at(k + 4, 5, 1'b1, "R3 shared ch5");
    expect_at(k + 4, 6, 1'b1, "R3 shared ch6");
    idle(6);

    // R9 reselect an edge channel to a pad that is already high
    set_pad(80, 1'b1, k);
    idle(4);
    reg_wr(4'h4, 32'h4750_8505, w);           // ch2 -> pad 80
    for (int d = 1; d <= 4; d++) expect_at(w + d, 2, 1'b0, "R9 no false edge");
    idle(5);
    reg_wr(4'h0, 32'h008A_000C, w);           // ch7 now active-low
    expect_at(w + 1, 7, 1'b1, "R9 level reload R3 out-of-range low");
    for (int d = 1; d <= 3; d++) expect_at(w + d, 2, 1'b0, "R9 trig write no edge");
    expect_at(w + 1, 1, 1'b1, "R9 ch1 unchanged");
    idle(5);
    reg_rd(4'h0, 32'h008A_000C, "R2 trig readback");

    while (sb.size() > 0) @(negedge clk);
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule